// File: doc/BRIEF.md
# Three-Slice Single-Cycle Integer Multiplier

This block performs the four 32-bit integer multiply operations of a RISC-style core. It returns the low word of the product, or the high word for three signedness combinations: signed by signed, signed by unsigned, and unsigned by unsigned. Three 17x17 signed multiplier slices work side by side, so each slice fits one FPGA DSP element. The low word is formed combinationally from three partial products and is ready in the cycle the operands are offered. A high-word request keeps a carry-extended intermediate sum in a register. In the following cycle one slice forms the product of the upper halves, and the high word appears.

The core raises `go_i` together with an operation code and two operands, then watches `done_o`. A low-word request completes at once. A high-word request completes in the next cycle, and any request offered during that second cycle is dropped. The last result stays on `prod_o` until the next completion.

Top module: `tri_slice_mul`

## Requirements
- R1: With `go_i` high, no high-word request pending and `kind_i` = 2'b00, `done_o` is 1 and `prod_o` equals bits 31..0 of `lhs_i * rhs_i` in that same cycle.
- R2: `kind_i` = 2'b01 returns bits 63..32 of the product with both operands treated as two's complement.
- R3: `kind_i` = 2'b10 returns bits 63..32 of the product with `lhs_i` signed and `rhs_i` unsigned.
- R4: `kind_i` = 2'b11 returns bits 63..32 of the product with both operands unsigned.
- R5: For a high-word request, `done_o` is 0 in the issue cycle and 1 in the cycle after it, with the result on `prod_o` in that second cycle.
- R6: A `go_i` offered during the second cycle of a high-word request is ignored. That cycle still completes the pending request, and the following cycle shows `done_o` = 0 with that result held.
- R7: Outside completion cycles, `done_o` is 0 and `prod_o` keeps the value of the most recent completion.
- R8: While `rst_ni` is low and after its release, with no request made, `done_o` is 0 and `prod_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Request strobe |
| kind_i | input | 2 | Operation: 00 low word, 01 high s*s, 10 high s*u, 11 high u*u |
| lhs_i | input | 32 | First operand |
| rhs_i | input | 32 | Second operand |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | 32 | Result, held between completions |

## Verification
If the registered intermediate carries a wrong sign extension or a lost carry, the error appears in the high word of the very next cycle. It shows up only for operands whose cross products are negative or overflow 32 bits, so the vectors include the extreme negative value, all-ones and mixed signs. A stuck pending flag shows up at once as a missing or doubled `done_o` pulse, or as a dropped request in the cycle after a high-word completion. A wrong hold register shows up as a changed `prod_o` one cycle after completion.

// File: rtl/mul3_pkg.sv
package mul3_pkg;
  typedef enum logic [1:0] {
    K_LOW   = 2'b00,
    K_HI_SS = 2'b01,
    K_HI_SU = 2'b10,
    K_HI_UU = 2'b11
  } mul_kind_e;

  function automatic logic lhs_signed(mul_kind_e k);
    return (k == K_HI_SS) || (k == K_HI_SU);
  endfunction

  function automatic logic rhs_signed(mul_kind_e k);
    return (k == K_HI_SS);
  endfunction
endpackage

// File: rtl/mul3_split.sv
module mul3_split #(
  parameter int unsigned XW = 32,
  localparam int unsigned HW = XW / 2,
  localparam int unsigned SW = HW + 1
) (
  input  logic                 [XW-1:0] val_i,
  input  logic                          sgn_i,
  output logic signed          [SW-1:0] lo_o,
  output logic signed          [SW-1:0] hi_o
);
  assign lo_o = {1'b0, val_i[HW-1:0]};
  assign hi_o = {sgn_i & val_i[XW-1], val_i[XW-1:HW]};
endmodule

// File: rtl/mul3_slice.sv
module mul3_slice #(
  parameter int unsigned SW = 17,
  localparam int unsigned PW = 2 * SW
) (
  input  logic signed [SW-1:0] x_i,
  input  logic signed [SW-1:0] y_i,
  output logic signed [PW-1:0] p_o
);
  assign p_o = x_i * y_i;
endmodule

// File: rtl/tri_slice_mul.sv
module tri_slice_mul
  import mul3_pkg::*;
#(
  parameter int unsigned XW = 32,
  parameter int unsigned NSLICE = 3,
  localparam int unsigned HW = XW / 2,
  localparam int unsigned SW = HW + 1,
  localparam int unsigned PW = 2 * SW,
  localparam int unsigned MW = PW + 1,
  localparam int unsigned IW = PW + 2,
  localparam int unsigned KW = IW - HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [1:0]    kind_i,
  input  logic [XW-1:0] lhs_i,
  input  logic [XW-1:0] rhs_i,
  output logic          done_o,
  output logic [XW-1:0] prod_o
);
  mul_kind_e kind;
  assign kind = mul_kind_e'(kind_i);

  logic signed [SW-1:0] a_lo, a_hi, b_lo, b_hi;

  mul3_split #(.XW(XW)) i_split_a (
    .val_i(lhs_i), .sgn_i(lhs_signed(kind)), .lo_o(a_lo), .hi_o(a_hi));
  mul3_split #(.XW(XW)) i_split_b (
    .val_i(rhs_i), .sgn_i(rhs_signed(kind)), .lo_o(b_lo), .hi_o(b_hi));

  // pending state and saved upper halves
  logic                 pend_q, pend_d;
  logic signed [SW-1:0] ahi_q, bhi_q;
  logic        [KW-1:0] acc_q;
  logic        [XW-1:0] hold_q, hold_d;
  logic                 hold_en;

  logic                 accept, fire_lo, fire_hi;
  assign accept  = go_i & ~pend_q;
  assign fire_lo = accept & (kind == K_LOW);
  assign fire_hi = accept & (kind != K_LOW);

  // slice operand selection: slice 0 is reused for hi*hi in the second cycle
  logic signed [SW-1:0] sx [NSLICE];
  logic signed [SW-1:0] sy [NSLICE];
  logic signed [PW-1:0] sp [NSLICE];

  always_comb begin
    sx[0] = pend_q ? ahi_q : a_lo;
    sy[0] = pend_q ? bhi_q : b_lo;
    sx[1] = a_lo;
    sy[1] = b_hi;
    sx[2] = a_hi;
    sy[2] = b_lo;
  end

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    mul3_slice #(.SW(SW)) i_slice (.x_i(sx[g]), .y_i(sy[g]), .p_o(sp[g]));
  end

  // combine partial products
  logic signed [MW-1:0] mid;
  logic signed [IW-1:0] inter;
  logic        [XW-1:0] lo_word, hi_word;

  always_comb begin
    mid     = {sp[1][PW-1], sp[1]} + {sp[2][PW-1], sp[2]};
    inter   = {{(IW-HW){1'b0}}, sp[0][XW-1:HW]} + {mid[MW-1], mid};
    lo_word = sp[0][XW-1:0] + {mid[HW-1:0], {HW{1'b0}}};
    hi_word = sp[0][XW-1:0] + {{(XW-KW){acc_q[KW-1]}}, acc_q};
  end

  logic unused_bits;
  assign unused_bits = ^{sp[0][PW-1:XW], inter[HW-1:0]};

  // next-state logic
  always_comb begin
    pend_d  = fire_hi;
    hold_en = fire_lo | pend_q;
    hold_d  = pend_q ? hi_word : lo_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_q <= '0;
      ahi_q  <= '0;
      bhi_q  <= '0;
      acc_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (hold_en) hold_q <= hold_d;
      if (fire_hi) begin
        ahi_q <= a_hi;
        bhi_q <= b_hi;
        acc_q <= inter[IW-1:HW];
      end
    end
  end

  assign done_o = fire_lo | pend_q;
  assign prod_o = hold_en ? hold_d : hold_q;

  AST_LOW_WORD_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !pend_q && kind_i == 2'b00) |-> (done_o && prod_o == lhs_i * rhs_i)); // R1
  AST_HIGH_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !pend_q && kind_i != 2'b00) |-> !done_o); // R5
  AST_HIGH_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !pend_q && kind_i != 2'b00) |=> done_o); // R5
  AST_NO_BACK_TO_BACK_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q); // R6
  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && $past(!done_o)) |-> $stable(prod_o)); // R7
endmodule

// File: tb/test_tri_slice_mul.sv
module test_tri_slice_mul;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk, rst_n, go;
  logic [1:0]  kind;
  logic [31:0] lhs, rhs;
  logic        done;
  logic [31:0] prod;
  int checks = 0;
  int fails = 0;

  tri_slice_mul i_tri_slice_mul (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .kind_i(kind),
    .lhs_i(lhs), .rhs_i(rhs), .done_o(done), .prod_o(prod));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {kind, lhs, rhs}
  localparam logic [65:0] VEC [NVEC] = '{
    {2'b00, 32'h0000_0007, 32'h0000_0006},
    {2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'b00, 32'h8000_0000, 32'h8000_0000},
    {2'b00, 32'h1234_5678, 32'h9ABC_DEF0},
    {2'b01, 32'h8000_0000, 32'h8000_0000},
    {2'b01, 32'hFFFF_FFFF, 32'h0000_0002},
    {2'b01, 32'h7FFF_FFFF, 32'h8000_0000},
    {2'b01, 32'h1234_5678, 32'hFEDC_BA98},
    {2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'b10, 32'h8000_0000, 32'h0000_FFFF},
    {2'b10, 32'h7FFF_8001, 32'hC000_0001},
    {2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'b11, 32'h8000_8000, 32'h0001_0001},
    {2'b11, 32'hDEAD_BEEF, 32'hCAFE_F00D}
  };

  function automatic logic [31:0] model(logic [1:0] k, logic [31:0] a, logic [31:0] b);
    logic signed [65:0] ea, eb;
    logic signed [131:0] p;
    ea = (k == 2'b01 || k == 2'b10) ? {{34{a[31]}}, a} : {34'b0, a};
    eb = (k == 2'b01) ? {{34{b[31]}}, b} : {34'b0, b};
    p = ea * eb;
    return (k == 2'b00) ? p[31:0] : p[63:32];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic offer(logic [1:0] k, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    go = 1'b1; kind = k; lhs = a; rhs = b;
    #1;
  endtask

  function automatic string tag(logic [1:0] k);
    case (k)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  logic [31:0] last;

  initial begin
    go = 1'b0; kind = 2'b00; lhs = '0; rhs = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 done in reset", {31'b0, done}, 32'd0);
    check("R8 prod in reset", prod, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R8 done after reset", {31'b0, done}, 32'd0);
    check("R8 prod after reset", prod, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] k;
      logic [31:0] a, b, e;
      k = VEC[i][65:64]; a = VEC[i][63:32]; b = VEC[i][31:0];
      e = model(k, a, b);
      offer(k, a, b);
      if (k == 2'b00) begin
        check("R1 done same cycle", {31'b0, done}, 32'd1);
        check(tag(k), prod, e);
      end else begin
        check("R5 no done at issue", {31'b0, done}, 32'd0);
        @(negedge clk);
        go = 1'b0; lhs = ~a; rhs = ~b; #1;
        check("R5 done second cycle", {31'b0, done}, 32'd1);
        check(tag(k), prod, e);
      end
      @(negedge clk);
      go = 1'b0; lhs = 32'h5A5A_5A5A; #1;
      check("R7 done low after", {31'b0, done}, 32'd0);
      check("R7 held result", prod, e);
    end

    // R6: request during pending second cycle is dropped
    last = model(2'b01, 32'hF000_0001, 32'h0F00_0003);
    offer(2'b01, 32'hF000_0001, 32'h0F00_0003);
    offer(2'b00, 32'h0000_0009, 32'h0000_0009);
    check("R6 pending completes", {31'b0, done}, 32'd1);
    check("R6 pending result", prod, last);
    @(negedge clk);
    go = 1'b0; #1;
    check("R6 ignored no done", {31'b0, done}, 32'd0);
    check("R6 ignored result held", prod, last);

    // R7: result unchanged over idle cycles with moving operands
    repeat (3) begin
      @(negedge clk);
      lhs = lhs + 32'd77; rhs = rhs ^ 32'hFFFF; kind = 2'b11; #1;
      check("R7 idle hold", prod, last);
    end

    // R8: reset mid-operation
    offer(2'b11, 32'h0000_FFFF, 32'h0000_FFFF);
    rst_n = 1'b0; go = 1'b0; #1;
    check("R8 reset clears done", {31'b0, done}, 32'd0);
    check("R8 reset clears prod", prod, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R8 no stale done", {31'b0, done}, 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule